// File: doc/BRIEF.md
# Sequential MSB-First GF(2^8) Multiplier

This block multiplies an 8-bit field element by a second 8-bit operand (the coefficient) in GF(2^8) under the reduction polynomial x^8+x^4+x^3+x+1. It works one coefficient bit per clock, starting at the most significant set bit. Each round shifts the running product left. When the bit shifted out was set, it folds in the low reduction byte. When the current coefficient bit is set, it adds the element.

Coefficient bits above the highest set bit would only shift a zero accumulator, so the block never spends cycles on them. The latency is therefore set by the coefficient, not fixed at eight cycles. This favours small constants such as those used in byte-column mixing: a coefficient of 0x01 finishes in one round, and 0x0E in four.

A caller raises `start` for one cycle while the block is idle. It then waits for the one-cycle `done` pulse and reads `product`.

Top module: `gf_msb_mul`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all 0.
- R2: A `start` sampled high while `busy` is low latches `s_in` and `con_in`, clears the accumulator, and `busy` is high from the next cycle on.
- R3: Let L be one plus the bit index of the highest set bit of the latched coefficient (L = 1 when the coefficient is 0). `done` is high in the cycle that follows the L-th rising edge after the accepting edge.
- R4: When `done` is high, `product` equals the GF(2^8) product of the latched element and coefficient, reduced by 0x11B (low reduction byte 0x1B).
- R5: `done` is high for exactly one cycle per operation. `busy` is low in that cycle.
- R6: A `start` sampled while `busy` is high is ignored. The running operation's result and latency are unchanged.
- R7: A coefficient of 0x00 gives `product` 0x00, with `done` high in the cycle after the first edge that follows the accepting edge.
- R8: While idle with no accepted `start`, `product` keeps the last result.
- R9: The column-mixing constants have these round counts: 0x01 takes 1, 0x02 and 0x03 take 2, and 0x09, 0x0B, 0x0D and 0x0E take 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| s_in | input | 8 | Field element operand |
| con_in | input | 8 | Coefficient operand, scanned from its top set bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| product | output | 8 | Running or final product |

## Verification
The bench builds the block with its defaults: an 8-bit width and a low reduction byte of 0x1B. Under these defaults every coefficient bit position from 0 to 7 can be reached, so all latencies from one to eight rounds occur. A shift-and-add reference that scans the coefficient from its least significant end supplies the expected products, and it does not share the block's ordering of the bits. Directed cases cover the zero coefficient, each column-mixing constant, 0x80 and 0xFF, and a start pulse injected mid-operation.

// File: rtl/gf_msb_mul.sv
module gf_msb_mul #(
  parameter int          WIDTH = 8,
  parameter logic [7:0]  RPOLY = 8'h1B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] s_in,
  input  logic [WIDTH-1:0] con_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] product
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] s_q, con_q, acc, acc_sh, acc_nx;
  logic [IW-1:0]    idx, top_idx;
  logic             take;

  assign take = start && !busy;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < WIDTH; i++)
      if (con_in[i]) top_idx = IW'(i);
  end

  assign acc_sh  = {acc[WIDTH-2:0], 1'b0} ^ (acc[WIDTH-1] ? WIDTH'(RPOLY) : '0);
  assign acc_nx  = acc_sh ^ (con_q[idx] ? s_q : '0);
  assign product = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      acc   <= '0;
      s_q   <= '0;
      con_q <= '0;
      idx   <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        s_q   <= s_in;
        con_q <= con_in;
        acc   <= '0;
        idx   <= top_idx;
        busy  <= 1'b1;
      end else if (busy) begin
        acc <= acc_nx;
        if (idx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end
endmodule

module gf_msb_mul_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] con_in,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] product
);
  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_zero_con_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && con_in == '0) |=> ##1 (done && product == '0));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> !done || !busy);
endmodule

bind gf_msb_mul gf_msb_mul_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_gf_msb_mul.sv
module sim_gf_msb_mul;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] s_in = '0, con_in = '0;
  logic       busy, done;
  logic [7:0] product;
  int checks = 0, failures = 0;

  gf_msb_mul u0 (.clk, .rst_n, .start, .s_in, .con_in, .busy, .done, .product);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    end
    return r;
  endfunction

  function automatic int ref_lat(logic [7:0] b);
    int l = 1;
    for (int i = 0; i < 8; i++) if (b[i]) l = i + 1;
    return l;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(logic [7:0] a, logic [7:0] b, bit inj, string req);
    int cnt = 0;
    logic [7:0] res;
    @(negedge clk);
    s_in = a; con_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s_in = ~a; con_in = 8'h01;
    chk(busy == 1'b1, "R2", busy, 1);
    while (!done && cnt < 20) begin
      start = (inj && cnt == 1 && !done) ? 1'b1 : 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    res = product;
    chk(cnt == ref_lat(b), {req, " R3 latency"}, cnt, ref_lat(b));
    chk(res == ref_mul(a, b), {req, " R4 product"}, res, ref_mul(a, b));
    chk(busy == 1'b0, "R5 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", done, 0);
    @(negedge clk);
    chk(product == res, "R8 product holds", product, res);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    #(3*CLK_PERIOD);
    chk(busy == 0 && done == 0 && product == 0, "R1 reset", {busy, done, product}, 0);
    @(negedge clk); rst_n = 1'b1;
    run(8'h57, 8'h00, 0, "R7 zero con");
    run(8'h00, 8'h00, 0, "R7 zero both");
    run(8'h57, 8'h83, 0, "R4 known");
    run(8'hD4, 8'h01, 0, "R9 c01");
    run(8'hD4, 8'h02, 0, "R9 c02");
    run(8'hBF, 8'h03, 0, "R9 c03");
    run(8'h5D, 8'h09, 0, "R9 c09");
    run(8'h30, 8'h0B, 0, "R9 c0B");
    run(8'hE5, 8'h0D, 0, "R9 c0D");
    run(8'hFF, 8'h0E, 0, "R9 c0E");
    run(8'h80, 8'h80, 0, "R3 top bit");
    run(8'hFF, 8'hFF, 0, "R4 all ones");
    run(8'hA7, 8'h0E, 1, "R6 start while busy");
    run(8'h3C, 8'hC1, 1, "R6 start while busy long");
    for (int n = 0; n < 300; n++)
      run(8'($urandom), 8'($urandom >> (($urandom % 8))), n % 5 == 0, "R4 random");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000*CLK_PERIOD);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule